// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block brings a peripheral's supply rails up and down in a fixed order. It drives one enable pin per voltage regulator and watches one power-good input per regulator. It also drives an all-rails-good output and an active-low reset to the peripheral. A single-cycle `req_on` pulse starts power-up and a single-cycle `req_off` pulse starts power-down. A free-running one-millisecond tick (`tick_ms`) sets every wait.

During power-up the block holds the peripheral in reset and turns the rails on one at a time. It moves to the next rail only after the current rail reports good. It raises all-rails-good once the last rail is good, and releases reset one tick period later. If any rail stays low for the whole timeout window, the block abandons power-up and runs the full shutdown. It then rests in the off state with a sticky fault bit set for that rail.

Power-down asserts reset and waits five tick periods. It then drops all-rails-good and turns the rails off in reverse order. A rail that will not drop within the timeout window is flagged, and the shutdown carries on with the remaining rails. Rail index 2 has an inverted enable pin. Its power-good input is active-high like all the others.

Top module: `rail_pwr_seq`

## Requirements
- R1: After reset, every rail is logically off (pin `rail_en` = 5'b00100), `periph_rst_n` = 0, `all_good` = 0, `st_off` = 1, `st_busy` = 0 and `fault_rail` = 0.
- R2: Power-up turns on rail 0 first, then rails 1, 2, 3 and 4. A rail is turned on only after the previous rail's power-good has been seen high through a two-flop synchronizer. The set of enabled rails is always a contiguous group starting at rail 0.
- R3: The enable pin of rail index 2 is the inverse of its logical state (pin 0 means on). The other enable pins are active-high. All power-good inputs are active-high.
- R4: `periph_rst_n` is low when the first rail is enabled. `all_good` rises only once all five rails are on and good. `periph_rst_n` rises only after `all_good` has been high for at least one tick period, which is between 2 and TICK+2 clock cycles for tick spacing TICK.
- R5: On `req_off` from the on state, `periph_rst_n` falls first. `all_good` falls five tick periods later, which is between 4*TICK+1 and 5*TICK+2 cycles. The rails then turn off in the order 4, 3, 2, 1, 0, each after the previous rail's power-good reads low. In the off state every rail is off, `all_good` = 0 and `periph_rst_n` = 0.
- R6: If a rail's power-good does not rise within 20 ticks during power-up, the block never raises `all_good` and never releases reset. It turns off the rails already on, in reverse order, and ends with `st_off` = 1. A power-good that rises after 15 ticks still counts as success.
- R7: If a rail's power-good does not fall within 20 ticks during power-down, that rail is flagged and the shutdown continues down to rail 0.
- R8: `req_on` and `req_off` have no effect while a sequence is running, `req_on` has no effect when on, and `req_off` has no effect when off.
- R9: `fault_rail` bit i is set when rail i times out in either direction. The bits stay set until the next successful power-up, which clears all of them.
- R10: Exactly one of `st_on`, `st_off` and `st_busy` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse |
| pgood_in | input | 5 | Power-good from each regulator, asynchronous |
| rail_en | output | 5 | Regulator enable pins (bit 2 active-low) |
| all_good | output | 1 | All rails good indication to the peripheral |
| periph_rst_n | output | 1 | Active-low peripheral reset |
| st_on | output | 1 | Sequence complete, rails up |
| st_off | output | 1 | Rails down, idle |
| st_busy | output | 1 | A sequence is in progress |
| fault_rail | output | 5 | Sticky per-rail timeout flags |

## Verification
The assertions assume two things about the inputs. First, `tick_ms` is a single-cycle pulse that recurs at a steady spacing. Second, each power-good input only changes after its rail's enable has changed, or stays stuck at its old level. The bench keeps to these assumptions with a regulator model. The model follows each logical enable after a chosen lag, or holds one chosen rail stuck low during power-up or stuck high during power-down. Requests are pulsed one cycle at a time, including pulses fired mid-sequence, so that the ignore rule is exercised.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [3:0] {
        S_OFF     = 4'd0,
        S_UP_EN   = 4'd1,
        S_UP_WAIT = 4'd2,
        S_UP_HOLD = 4'd3,
        S_ON      = 4'd4,
        S_DN_RST  = 4'd5,
        S_DN_EN   = 4'd6,
        S_DN_WAIT = 4'd7
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rps_sync2.sv
module rps_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/rps_tick_timer.sv
module rps_tick_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != {CW{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/rps_pin_drive.sv
module rps_pin_drive #(
    parameter int          N    = 5,
    parameter logic [N-1:0] INV = '0
) (
    input  logic [N-1:0] on_l,
    output logic [N-1:0] pin
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        if (INV[i]) begin : g_inv
            assign pin[i] = ~on_l[i];
        end else begin : g_true
            assign pin[i] = on_l[i];
        end
    end
endmodule

// File: rtl/rail_pwr_seq.sv
module rail_pwr_seq
    import rps_pkg::*;
#(
    parameter int                 N_RAILS       = 5,
    parameter logic [N_RAILS-1:0] ACTLOW_MASK   = 5'b00100,
    parameter int                 TIMEOUT_TICKS = 20,
    parameter int                 RST_DLY_TICKS = 5,
    parameter int                 GOOD_DLY_TICKS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_ms,
    input  logic               req_on,
    input  logic               req_off,
    input  logic [N_RAILS-1:0] pgood_in,
    output logic [N_RAILS-1:0] rail_en,
    output logic               all_good,
    output logic               periph_rst_n,
    output logic               st_on,
    output logic               st_off,
    output logic               st_busy,
    output logic [N_RAILS-1:0] fault_rail
);
    localparam int IW     = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
    localparam int MAXLIM = max3(TIMEOUT_TICKS, RST_DLY_TICKS, GOOD_DLY_TICKS);
    localparam int CW     = $clog2(MAXLIM + 1) + 1;
    localparam logic [IW-1:0] LAST = IW'(N_RAILS - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [IW-1:0]      idx;
        logic [N_RAILS-1:0] on;
        logic               good;
        logic               prst_n;
        logic [N_RAILS-1:0] fault;
    } regs_t;

    regs_t              r_d;
    regs_t              r_q;
    logic               tmr_clr;
    logic [CW-1:0]      tmr_cnt;
    logic [N_RAILS-1:0] pg_s;
    logic               t_out;
    logic               t_rst;
    logic               t_good;

    rps_sync2 #(.W(N_RAILS)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pgood_in),
        .dout (pg_s)
    );

    rps_tick_timer #(.CW(CW)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .tick (tick_ms),
        .count(tmr_cnt)
    );

    rps_pin_drive #(.N(N_RAILS), .INV(ACTLOW_MASK)) i_pins (
        .on_l(r_q.on),
        .pin (rail_en)
    );

    assign t_out  = (tmr_cnt >= CW'(TIMEOUT_TICKS));
    assign t_rst  = (tmr_cnt >= CW'(RST_DLY_TICKS));
    assign t_good = (tmr_cnt >= CW'(GOOD_DLY_TICKS));

    always_comb begin
        r_d     = r_q;
        tmr_clr = 1'b0;
        case (r_q.st)
            S_OFF: begin
                if (req_on) begin
                    r_d.prst_n = 1'b0;
                    r_d.idx    = '0;
                    r_d.st     = S_UP_EN;
                end
            end
            S_UP_EN: begin
                r_d.on[r_q.idx] = 1'b1;
                tmr_clr         = 1'b1;
                r_d.st          = S_UP_WAIT;
            end
            S_UP_WAIT: begin
                if (pg_s[r_q.idx]) begin
                    tmr_clr = 1'b1;
                    if (r_q.idx == LAST) begin
                        r_d.good = 1'b1;
                        r_d.st   = S_UP_HOLD;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = S_UP_EN;
                    end
                end else if (t_out) begin
                    r_d.fault[r_q.idx] = 1'b1;
                    tmr_clr            = 1'b1;
                    r_d.st             = S_DN_RST;
                end
            end
            S_UP_HOLD: begin
                if (t_good) begin
                    r_d.prst_n = 1'b1;
                    r_d.fault  = '0;
                    r_d.st     = S_ON;
                end
            end
            S_ON: begin
                if (req_off) begin
                    r_d.prst_n = 1'b0;
                    tmr_clr    = 1'b1;
                    r_d.st     = S_DN_RST;
                end
            end
            S_DN_RST: begin
                if (t_rst) begin
                    r_d.good = 1'b0;
                    r_d.idx  = LAST;
                    r_d.st   = S_DN_EN;
                end
            end
            S_DN_EN: begin
                r_d.on[r_q.idx] = 1'b0;
                tmr_clr         = 1'b1;
                r_d.st          = S_DN_WAIT;
            end
            S_DN_WAIT: begin
                if (!pg_s[r_q.idx] || t_out) begin
                    if (pg_s[r_q.idx]) begin
                        r_d.fault[r_q.idx] = 1'b1;
                    end
                    if (r_q.idx == '0) begin
                        r_d.st = S_OFF;
                    end else begin
                        r_d.idx = r_q.idx - 1'b1;
                        r_d.st  = S_DN_EN;
                    end
                end
            end
            default: begin
                r_d.st = S_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= S_OFF;
            r_q.idx    <= '0;
            r_q.on     <= '0;
            r_q.good   <= 1'b0;
            r_q.prst_n <= 1'b0;
            r_q.fault  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign all_good     = r_q.good;
    assign periph_rst_n = r_q.prst_n;
    assign st_on        = (r_q.st == S_ON);
    assign st_off       = (r_q.st == S_OFF);
    assign st_busy      = !st_on && !st_off;
    assign fault_rail   = r_q.fault;
endmodule

// File: rtl/rail_pwr_seq_chk.sv
module rail_pwr_seq_chk #(
    parameter int                 N_RAILS     = 5,
    parameter logic [N_RAILS-1:0] ACTLOW_MASK = 5'b00100
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_RAILS-1:0] rail_en,
    input logic               all_good,
    input logic               periph_rst_n,
    input logic               st_on,
    input logic               st_off,
    input logic               st_busy,
    input logic [N_RAILS-1:0] fault_rail
);
    logic [N_RAILS-1:0] on_l;
    assign on_l = rail_en ^ ACTLOW_MASK;

    p_status_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_on, st_off, st_busy}) == 1);

    p_en_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((on_l + 1'b1) & on_l) == '0);

    p_good_all_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        all_good |-> (&on_l));

    p_rst_after_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_rst_n) |-> (all_good && $past(all_good)));

    p_rst_before_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(all_good) |-> !periph_rst_n);

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_off |-> (on_l == '0 && !all_good && !periph_rst_n));

    p_on_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_on |-> (fault_rail == '0 && all_good && periph_rst_n && (&on_l)));
endmodule

bind rail_pwr_seq rail_pwr_seq_chk #(
    .N_RAILS    (N_RAILS),
    .ACTLOW_MASK(ACTLOW_MASK)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rail_en     (rail_en),
    .all_good    (all_good),
    .periph_rst_n(periph_rst_n),
    .st_on       (st_on),
    .st_off      (st_off),
    .st_busy     (st_busy),
    .fault_rail  (fault_rail)
);

// File: tb/test_rail_pwr_seq.sv
`timescale 1ns/1ps
module test_rail_pwr_seq;
    localparam int N    = 5;
    localparam logic [N-1:0] INV = 5'b00100;
    localparam int TICK = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic req_on = 1'b0;
    logic req_off = 1'b0;
    logic [N-1:0] pgood_in = '0;
    logic [N-1:0] rail_en;
    logic all_good, periph_rst_n, st_on, st_off, st_busy;
    logic [N-1:0] fault_rail;

    always #2.5 clk = ~clk;

    rail_pwr_seq i_rail_pwr_seq (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .req_on(req_on),
        .req_off(req_off), .pgood_in(pgood_in), .rail_en(rail_en),
        .all_good(all_good), .periph_rst_n(periph_rst_n), .st_on(st_on),
        .st_off(st_off), .st_busy(st_busy), .fault_rail(fault_rail)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // regulator model
    int lag = 4;
    logic [N-1:0] stuck_lo = '0;
    logic [N-1:0] stuck_hi = '0;
    int pcnt [N];
    logic [N-1:0] on_l;
    assign on_l = rail_en ^ INV;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick_ms <= ((cyc % TICK) == TICK - 1);
        for (int i = 0; i < N; i++) begin
            logic tgt;
            tgt = on_l[i];
            if (stuck_lo[i]) tgt = 1'b0;
            if (stuck_hi[i] && pgood_in[i]) tgt = 1'b1;
            if (pgood_in[i] != tgt) begin
                if (pcnt[i] >= lag) begin
                    pgood_in[i] <= tgt;
                    pcnt[i] <= 0;
                end else begin
                    pcnt[i] <= pcnt[i] + 1;
                end
            end else begin
                pcnt[i] <= 0;
            end
        end
    end

    // port monitor
    int ev_q[$];
    int exp_q[$];
    logic [N-1:0] on_prev = '0;
    logic good_prev = 1'b0, rst_prev = 1'b0;
    int t_good_rise, t_good_fall, t_rst_rise, t_rst_fall;
    int n_good_rise, n_rst_rise, n_en_while_rel;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (on_l[i] && !on_prev[i]) begin
                    ev_q.push_back(16 + i);
                    if (periph_rst_n) n_en_while_rel++;
                end
                if (!on_l[i] && on_prev[i]) ev_q.push_back(i);
            end
            if (all_good && !good_prev) begin t_good_rise = cyc; n_good_rise++; end
            if (!all_good && good_prev) t_good_fall = cyc;
            if (periph_rst_n && !rst_prev) begin t_rst_rise = cyc; n_rst_rise++; end
            if (!periph_rst_n && rst_prev) t_rst_fall = cyc;
        end
        on_prev   = on_l;
        good_prev = all_good;
        rst_prev  = periph_rst_n;
    end

    task automatic clear_log();
        ev_q.delete();
        exp_q.delete();
        n_good_rise = 0; n_rst_rise = 0; n_en_while_rel = 0;
        t_good_rise = 0; t_good_fall = 0; t_rst_rise = 0; t_rst_fall = 0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic chk_log(input string req);
        bit same;
        same = (ev_q.size() == exp_q.size());
        if (same) begin
            for (int i = 0; i < ev_q.size(); i++) if (ev_q[i] != exp_q[i]) same = 0;
        end
        chk(same, req, ev_q.size(), exp_q.size());
    endtask

    // bench functions for expected event order
    function automatic void exp_up(input int last);
        for (int i = 0; i <= last; i++) exp_q.push_back(16 + i);
    endfunction
    function automatic void exp_down(input int first);
        for (int i = first; i >= 0; i--) exp_q.push_back(i);
    endfunction

    task automatic pulse(input bit on);
        @(posedge clk); #1;
        if (on) req_on = 1'b1; else req_off = 1'b1;
        @(posedge clk); #1;
        req_on = 1'b0; req_off = 1'b0;
    endtask

    task automatic wait_idle();
        int g;
        g = 0;
        repeat (3) @(posedge clk);
        while (st_busy && g < 20000) begin @(posedge clk); g++; end
        #1;
    endtask

    logic [N-1:0] exp_fault = '0;

    task automatic do_on(input int lg, input int stuck, input bit poke, input string rq);
        clear_log();
        lag = lg;
        stuck_lo = (stuck >= 0) ? (N'(1) << stuck) : '0;
        pulse(1'b1);
        if (poke) begin repeat (30) @(posedge clk); pulse(1'b0); end
        wait_idle();
        if (stuck < 0) begin
            exp_up(N - 1);
            exp_fault = '0;
            chk_log({rq, " R2 up order"});
            chk(st_on && all_good && periph_rst_n, {rq, " R2 on state"}, {st_on, all_good, periph_rst_n}, 3'b111);
            chk(rail_en == ~INV, "R3 pins when on", rail_en, ~INV);
            chk(n_en_while_rel == 0, "R4 reset low at enable", n_en_while_rel, 0);
            chk((t_rst_rise - t_good_rise) >= 2 && (t_rst_rise - t_good_rise) <= TICK + 2,
                "R4 good-to-release gap", t_rst_rise - t_good_rise, TICK);
        end else begin
            exp_up(stuck);
            exp_down(stuck);
            exp_fault = exp_fault | (N'(1) << stuck);
            chk_log({rq, " R6 abort order"});
            chk(st_off && rail_en == INV, "R6 ends off", rail_en, INV);
            chk(n_good_rise == 0 && n_rst_rise == 0, "R6 no good/release",
                n_good_rise + n_rst_rise, 0);
        end
        chk(fault_rail == exp_fault, {rq, " R9 fault bits"}, fault_rail, exp_fault);
        stuck_lo = '0;
        repeat (4 * lg + 20) @(posedge clk); #1;
    endtask

    task automatic do_off(input int lg, input int stuck, input bit poke, input string rq);
        clear_log();
        lag = lg;
        stuck_hi = (stuck >= 0) ? (N'(1) << stuck) : '0;
        pulse(1'b0);
        if (poke) begin repeat (30) @(posedge clk); pulse(1'b1); end
        wait_idle();
        exp_down(N - 1);
        if (stuck >= 0) exp_fault = exp_fault | (N'(1) << stuck);
        chk_log({rq, " R5 down order"});
        chk(st_off && !all_good && !periph_rst_n && rail_en == INV, {rq, " R5 off state"}, rail_en, INV);
        chk((t_good_fall - t_rst_fall) >= 4 * TICK + 1 && (t_good_fall - t_rst_fall) <= 5 * TICK + 2,
            "R5 reset-to-drop gap", t_good_fall - t_rst_fall, 5 * TICK);
        chk(fault_rail == exp_fault, {rq, " R7 fault after down"}, fault_rail, exp_fault);
        stuck_hi = '0;
        repeat (2 * lg + 20) @(posedge clk); #1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) pcnt[i] = 0;
        clear_log();
        repeat (5) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 / R3 reset state
        chk(rail_en == INV, "R1 R3 reset pins", rail_en, INV);
        chk(!periph_rst_n && !all_good, "R1 reset outputs", {periph_rst_n, all_good}, 0);
        chk(st_off && !st_busy && !st_on && fault_rail == '0, "R1 status", {st_on, st_off, st_busy}, 3'b010);

        // R8 off request while off
        clear_log();
        pulse(1'b0);
        repeat (50) @(posedge clk); #1;
        chk(st_off && ev_q.size() == 0 && rail_en == INV, "R8 off while off", ev_q.size(), 0);

        do_on(7, -1, 1'b0, "dir1");

        // R8 on request while on
        clear_log();
        pulse(1'b1);
        repeat (50) @(posedge clk); #1;
        chk(st_on && ev_q.size() == 0 && periph_rst_n, "R8 on while on", ev_q.size(), 0);

        do_off(5, -1, 1'b1, "dir2 R8");
        do_on(3, 3, 1'b0, "dir3");
        do_on(6, -1, 1'b1, "dir4 R8 R9");
        do_off(4, 1, 1'b0, "dir5");
        do_on(300, -1, 1'b0, "dir6 R6 slow");
        do_off(2, -1, 1'b0, "dir7");
        do_on(2, 0, 1'b0, "dir8 first");
        do_on(2, 4, 1'b0, "dir9 last");

        for (int it = 0; it < 8; it++) begin
            int lg, r;
            lg = int'($urandom % 40);
            r  = int'($urandom % 8);
            do_on(lg, (r < N) ? r : -1, 1'b0, "rnd");
            if (st_on) begin
                r = int'($urandom % 8);
                do_off(int'($urandom % 40), (r < N) ? r : -1, 1'b0, "rnd");
            end
        end
        chk(st_off || st_on, "R10 final status", {st_on, st_off, st_busy}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 180000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 180000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule